// File: doc/BRIEF.md
# I2C Target Address-Match Wake-Up Controller

This block watches an I2C target port while the rest of the chip is asleep. A START condition is caught by an edge-triggered latch that needs no running clock. That latch holds SCL low and raises a clock request toward the power controller. When the power controller reports that the clock is running, the block releases SCL and receives the first byte. It compares the 7-bit address against a primary address and up to three more addresses, each of which can be enabled on its own.

The block can also be set to compare the first data byte against a programmable value. A complete match raises a system wake output and a sticky target-access flag, and the normal target logic then takes over the transfer. On a mismatch, or if a STOP or repeated START cuts the attempt short, the block drops its clock request and goes back to idle without waking anything. When the system is already active, data comparison is forced off, so the address alone decides the wake.

Top module: `i2c_wake_top`

## Requirements
- R1: After reset, clk_req_o, scl_pull_o, sda_pull_o, wake_o and tgt_acc_o are all 0.
- R2: In idle, an SDA falling edge while SCL is high sets scl_pull_o and clk_req_o at once, with no clk_i edge needed.
- R3: scl_pull_o stays 1 while clk_rdy_i is 0. It returns to 0 within a few clk_i cycles after clk_rdy_i goes to 1.
- R4: The first byte is sampled on SCL rising edges, MSB first. Its upper 7 bits are the address. If that address equals own_addr_i, or equals any alt_addr_i slot k (bits 7k+6..7k) whose alt_en_i[k] is 1, then sda_pull_o is 1 (ACK) during the ninth SCL clock.
- R5: An address that matches nothing, including a disabled slot, gets no ACK (sda_pull_o stays 0). The block returns to idle and clk_req_o drops to 0.
- R6: wake_o stays 0 through the address and data phases. It becomes 1 only after a complete match, once the final ACK clock has ended.
- R7: tgt_acc_o becomes 1 together with wake_o. wake_o holds until resume_i, which returns the block to idle. tgt_acc_o then holds until acc_clr_i.
- R8: With data_match_en_i=1 and sys_active_i=0, the 8-bit byte after the address must equal data_match_val_i. A match gives an ACK and a wake. A mismatch gives no ACK, no wake, and a return to idle.
- R9: With sys_active_i=1, data comparison is off, and a matched address alone produces the wake.
- R10: A STOP (SDA rising while SCL is high) before matching finishes sends the block back to idle with clk_req_o at 0.
- R11: A repeated START before matching finishes also sends the block back to idle. The START latch only arms in idle, so address bits that follow produce no ACK and no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, valid while clk_rdy_i is high |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK) |
| clk_req_o | output | 1 | Clock request to the power controller |
| clk_rdy_i | input | 1 | Power controller reports clock running |
| own_addr_i | input | 7 | Primary target address |
| alt_addr_i | input | 21 | Three extra addresses, slot k at bits 7k+6..7k |
| alt_en_i | input | 3 | Per-slot enable for the extra addresses |
| data_match_en_i | input | 1 | Extend matching to the first data byte |
| data_match_val_i | input | 8 | Value the first data byte must equal |
| sys_active_i | input | 1 | System awake; forces data matching off |
| wake_o | output | 1 | System wake request |
| tgt_acc_o | output | 1 | Sticky flag: this block caused the wake |
| resume_i | input | 1 | System has taken over; block returns to idle |
| acc_clr_i | input | 1 | Clears tgt_acc_o |

## Verification
The bench runs a full bus transaction for each case:
- a primary match
- a match on an enabled extra slot
- a miss on a disabled slot, which shows whether the enable bits are ignored
- a data-byte match and a data-byte miss
- data comparison under an active system

A design that released SCL early would show scl_pull_o low before clk_rdy_i. A design that woke early would show wake_o rising during the address phase, which the per-cycle comparison of wake_o catches. Two aborted attempts, one cut by a STOP and one by a repeated START, check that the clock request is dropped. They also check that a START latch armed outside idle does not let a later address wake the system.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_DATA,
    S_DACK,
    S_WAKE
  } wk_state_e;
endpackage

// File: rtl/i2c_wake_sync.sv
module i2c_wake_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[b]}};
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_wake_start_det.sv
module i2c_wake_start_det (
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  // Clockless START capture: SDA fall while SCL high, only when armed.
  always_ff @(negedge sda_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)              flag_o <= 1'b0;
    else if (clr_i)           flag_o <= 1'b0;
    else if (scl_i && arm_i)  flag_o <= 1'b1;
  end
endmodule

// File: rtl/i2c_wake_match.sv
module i2c_wake_match #(
  parameter int ADDR_W  = 7,
  parameter int NUM_ALT = 3
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [ADDR_W-1:0]         own_i,
  input  logic [NUM_ALT*ADDR_W-1:0] alt_i,
  input  logic [NUM_ALT-1:0]        alt_en_i,
  output logic                      hit_o
);
  logic [NUM_ALT-1:0] alt_hit;
  for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
    assign alt_hit[k] = alt_en_i[k] && (addr_i == alt_i[k*ADDR_W +: ADDR_W]);
  end
  assign hit_o = (addr_i == own_i) || (|alt_hit);
endmodule

// File: rtl/i2c_wake_top.sv
module i2c_wake_top
  import i2c_wake_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int NUM_ALT     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      scl_pull_o,
  output logic                      sda_pull_o,
  output logic                      clk_req_o,
  input  logic                      clk_rdy_i,
  input  logic [ADDR_W-1:0]         own_addr_i,
  input  logic [NUM_ALT*ADDR_W-1:0] alt_addr_i,
  input  logic [NUM_ALT-1:0]        alt_en_i,
  input  logic                      data_match_en_i,
  input  logic [ADDR_W:0]           data_match_val_i,
  input  logic                      sys_active_i,
  output logic                      wake_o,
  output logic                      tgt_acc_o,
  input  logic                      resume_i,
  input  logic                      acc_clr_i
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  wk_state_e         state;
  logic              start_flag, det_clr, arm;
  logic              scl_s, sda_s, flag_s, scl_d, sda_d;
  logic              scl_rise, scl_fall, bus_evt;
  logic [BYTE_W-1:0] shreg, new_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_on, acc_q, addr_hit, data_hit, dm_eff;

  assign arm = (state == S_IDLE);

  i2c_wake_start_det u_det (
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .arm_i  (arm),
    .clr_i  (det_clr),
    .flag_o (start_flag)
  );

  i2c_wake_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i, start_flag}),
    .q_o    ({scl_s, sda_s, flag_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // START or STOP on the bus: SDA moves while SCL high
  assign bus_evt  = scl_s & scl_d & (sda_s ^ sda_d);

  assign new_byte = {shreg[BYTE_W-2:0], sda_s};
  assign data_hit = (new_byte == data_match_val_i);
  assign dm_eff   = data_match_en_i & ~sys_active_i;

  i2c_wake_match #(
    .ADDR_W  (ADDR_W),
    .NUM_ALT (NUM_ALT)
  ) u_match (
    .addr_i   (new_byte[BYTE_W-1:1]),
    .own_i    (own_addr_i),
    .alt_i    (alt_addr_i),
    .alt_en_i (alt_en_i),
    .hit_o    (addr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      ack_on  <= 1'b0;
      det_clr <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      det_clr <= 1'b0;
      if (acc_clr_i) acc_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (flag_s && clk_rdy_i) begin
            state   <= S_ADDR;
            bit_cnt <= '0;
            det_clr <= 1'b1;
          end
        end
        S_ADDR, S_DATA: begin
          if (bus_evt) begin
            state <= S_IDLE;
          end else if (scl_rise) begin
            shreg <= new_byte;
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              if (state == S_ADDR) state <= addr_hit ? S_AACK : S_IDLE;
              else                 state <= data_hit ? S_DACK : S_IDLE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        S_AACK, S_DACK: begin
          if (bus_evt) begin
            state  <= S_IDLE;
            ack_on <= 1'b0;
          end else if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              if (state == S_AACK && dm_eff) begin
                state <= S_DATA;
              end else begin
                state <= S_WAKE;
                acc_q <= 1'b1;
              end
            end
          end
        end
        S_WAKE: begin
          if (resume_i) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign scl_pull_o = start_flag;
  assign sda_pull_o = ack_on;
  assign clk_req_o  = start_flag | (state != S_IDLE);
  assign wake_o     = (state == S_WAKE);
  assign tgt_acc_o  = acc_q;
endmodule

// File: rtl/i2c_wake_chk.sv
module i2c_wake_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_rdy_i,
  input logic acc_clr_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic clk_req_o,
  input logic wake_o,
  input logic tgt_acc_o
);
  a_r2_stretch_requests_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o |-> clk_req_o);

  a_r3_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o && !clk_rdy_i |=> scl_pull_o);

  a_r4_ack_needs_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> clk_req_o);

  a_r6_no_ack_while_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !sda_pull_o);

  a_r7_wake_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> tgt_acc_o);

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_acc_o && !acc_clr_i |=> tgt_acc_o);
endmodule

bind i2c_wake_top i2c_wake_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_rdy_i  (clk_rdy_i),
  .acc_clr_i  (acc_clr_i),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .clk_req_o  (clk_req_o),
  .wake_o     (wake_o),
  .tgt_acc_o  (tgt_acc_o)
);

// File: tb/i2c_wake_top_test.sv
`timescale 1ns/1ps
module i2c_wake_top_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic clk_rdy = 1'b0, sys_active = 1'b0, dm_en = 1'b0;
  logic resume = 1'b0, acc_clr = 1'b0;
  logic [7:0]  dm_val = 8'hA5;
  logic [6:0]  own_addr = 7'h2A;
  logic [20:0] alt_addr = {7'h51, 7'h33, 7'h12};
  logic [2:0]  alt_en = 3'b101;
  logic scl_pull, sda_pull, clk_req, wake, tacc;
  wire  scl_line = scl_m & ~scl_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 1'b0, exp_wake = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  i2c_wake_top uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .clk_req_o(clk_req),
    .clk_rdy_i(clk_rdy), .own_addr_i(own_addr), .alt_addr_i(alt_addr),
    .alt_en_i(alt_en), .data_match_en_i(dm_en), .data_match_val_i(dm_val),
    .sys_active_i(sys_active), .wake_o(wake), .tgt_acc_o(tacc),
    .resume_i(resume), .acc_clr_i(acc_clr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference of the wake output (R6)
  always begin
    @(posedge clk); #2;
    if (cmp_on) chk("R6 wake per-cycle", wake, exp_wake);
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;  wt(Q);
    scl_m = 1'b1; wt(2*Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic byte_out(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic ack_clk(output logic acked);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    acked = sda_pull;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_start_wait();
    scl_m = 1'b1; sda_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(1);
    chk("R2 stretch on START", scl_pull, 1'b1);
    chk("R2 request on START", clk_req, 1'b1);
    wt(Q);
    scl_m = 1'b0; wt(Q);
    chk("R3 still held without ready", scl_pull, 1'b1);
    clk_rdy = 1'b1; wt(Q);
    chk("R3 released after ready", scl_pull, 1'b0);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic xfer(input string req, input logic [6:0] a, input bit send_data,
                      input logic [7:0] d, input bit exp_aack, input bit exp_dack,
                      input bit exp_wk);
    logic ak;
    exp_wake = 1'b0; cmp_on = 1'b1;
    bus_start_wait();
    byte_out({a, 1'b0});
    if (!(exp_aack && !send_data)) cmp_on = 1'b1;
    if (exp_aack && !send_data) cmp_on = 1'b0;
    ack_clk(ak);
    chk({req, " address ack"}, ak, exp_aack);
    if (!exp_aack) chk("R5 request dropped on miss", clk_req, 1'b0);
    if (send_data && exp_aack) begin
      byte_out(d);
      cmp_on = 1'b0;
      ack_clk(ak);
      chk({req, " data ack"}, ak, exp_dack);
      if (!exp_dack) chk("R8 request dropped on data miss", clk_req, 1'b0);
    end
    wt(2);
    exp_wake = exp_wk; cmp_on = 1'b1;
    chk({req, " wake"}, wake, exp_wk);
    chk("R7 access flag with wake", tacc, exp_wk);
    bus_stop();
    if (exp_wk) begin
      chk("R7 wake held until resume", wake, 1'b1);
      cmp_on = 1'b0;
      resume = 1'b1; wt(1); resume = 1'b0; wt(2);
      exp_wake = 1'b0; cmp_on = 1'b1;
      chk("R7 wake cleared by resume", wake, 1'b0);
      chk("R7 flag survives resume", tacc, 1'b1);
      chk("R7 idle after resume", clk_req, 1'b0);
      acc_clr = 1'b1; wt(1); acc_clr = 1'b0; wt(1);
      chk("R7 flag cleared", tacc, 1'b0);
    end
    clk_rdy = 1'b0; wt(Q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ak;
    wt(3);
    chk("R1 clk_req reset", clk_req, 1'b0);
    chk("R1 scl_pull reset", scl_pull, 1'b0);
    chk("R1 sda_pull reset", sda_pull, 1'b0);
    chk("R1 wake reset", wake, 1'b0);
    chk("R1 tacc reset", tacc, 1'b0);
    rst_n = 1'b1; wt(4);
    chk("R1 idle after reset", clk_req, 1'b0);

    xfer("R4 primary", 7'h2A, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    xfer("R4 enabled slot 2", 7'h51, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    xfer("R5 disabled slot 1", 7'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    xfer("R5 unknown address", 7'h7F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    dm_en = 1'b1;
    xfer("R8 data hit", 7'h12, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b1);
    xfer("R8 data miss", 7'h2A, 1'b1, 8'hA4, 1'b1, 1'b0, 1'b0);
    sys_active = 1'b1;
    xfer("R9 active ignores data", 7'h2A, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    sys_active = 1'b0; dm_en = 1'b0;

    // R10: STOP mid-address
    exp_wake = 1'b0; cmp_on = 1'b1;
    bus_start_wait();
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_stop(); wt(2);
    chk("R10 idle after STOP", clk_req, 1'b0);
    chk("R10 no wake after STOP", wake, 1'b0);
    clk_rdy = 1'b0; wt(Q);

    // R11: repeated START mid-address
    bus_start_wait();
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    chk("R11 idle after repeated START", clk_req, 1'b0);
    chk("R11 latch not armed", scl_pull, 1'b0);
    scl_m = 1'b0; wt(Q);
    byte_out({7'h2A, 1'b0});
    ack_clk(ak);
    chk("R11 no ack after abort", ak, 1'b0);
    wt(2);
    chk("R11 no wake after abort", wake, 1'b0);
    bus_stop();
    clk_rdy = 1'b0; wt(Q);

    xfer("R4 primary after aborts", 7'h2A, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule